// File: doc/BRIEF.md
# OTG Interrupt Status and Line-State Monitor

This block watches the slow control signals of a USB On-The-Go port and turns their changes into latched interrupt flags. It follows the connector ID pin, the A-device VBUS-valid level, the B-device session-valid and session-end levels, and the two-bit bus line state. It also runs a free-running one-millisecond timer whose expiry is itself a flag.

Each level input passes through a two-flop synchronizer and then an edge detector, so a change in either direction sets its flag. The line state is treated differently: a new value must hold steady for one full millisecond, and it is reported only when that settled value differs from the last settled value. A short glitch that returns to the old state raises nothing.

Software sees an 8-bit status word with write-one-to-clear flags and an 8-bit enable word with the same layout. The interrupt line is high while any enabled flag is set. The register bus is a single write strobe with a select bit. Both words are always presented as 32-bit readback outputs.

Top module: `otg_irq_monitor`

## Requirements
- R1: After reset, status_o, enable_o and irq_o are all zero.
- R2: A change of id_i in either direction sets status bit 7.
- R3: A change in either direction sets a status bit: avbus_vld_i sets bit 0, bsess_end_i sets bit 2, and bsess_vld_i sets bit 3.
- R4: Status bit 6 sets each time the internal timer expires, once every CYCLES_PER_MS clock cycles.
- R5: line_i is coded 2'b00 SE0, 2'b01 J and 2'b10 K, and the settled value starts at J. Status bit 5 sets only after line_i has held one value for CYCLES_PER_MS cycles and that value differs from the previous settled value. A change that lasts less than the window sets nothing, and a value that stays settled does not set the bit again.
- R6: A write with wr_sel_i=0 clears every implemented status bit whose wr_data_i bit is 1 and leaves the bits written 0 unchanged. Status bits 31:8, 4 and 1 always read 0.
- R7: A write with wr_sel_i=1 loads the enable bits 7,6,5,3,2,0 from wr_data_i. Enable bits 31:8, 4 and 1 always read 0.
- R8: irq_o is 1 exactly when some status bit and its enable bit are both 1.
- R9: When a flag sets in the same cycle that a status write clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| id_i | input | 1 | Connector ID level, asynchronous |
| avbus_vld_i | input | 1 | A-device VBUS-valid level, asynchronous |
| bsess_vld_i | input | 1 | B-device session-valid level, asynchronous |
| bsess_end_i | input | 1 | B-device session-end level, asynchronous |
| line_i | input | 2 | Bus line state: 00 SE0, 01 J, 10 K |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 status (clear), 1 enable |
| wr_data_i | input | 32 | Write data |
| status_o | output | 32 | Status word readback |
| enable_o | output | 32 | Enable word readback |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a status write that clears a flag in the same clock in which hardware sets that flag. The bench hits that clock by counting edges. It toggles id_i away from a clock edge, waits through the two synchronizer stages, and places the clearing write on the third edge, where the edge detector fires. It then confirms the flag is still set. The line filter is driven with glitches shorter than the millisecond window, with real changes held past it, and with a settled value held longer still, to show that the flag sets at the right time and only once.

// File: rtl/otg_irq_pkg.sv
package otg_irq_pkg;
  localparam int unsigned STAT_W = 8;

  localparam int unsigned BIT_AVBUS = 0;
  localparam int unsigned BIT_BEND  = 2;
  localparam int unsigned BIT_BVLD  = 3;
  localparam int unsigned BIT_LINE  = 5;
  localparam int unsigned BIT_TICK  = 6;
  localparam int unsigned BIT_ID    = 7;

  localparam logic [STAT_W-1:0] IMPL_MASK = 8'b1110_1101;

  typedef enum logic [1:0] {
    LINE_SE0 = 2'b00,
    LINE_J   = 2'b01,
    LINE_K   = 2'b10,
    LINE_SE1 = 2'b11
  } line_e;
endpackage

// File: rtl/otg_sync.sv
module otg_sync #(
  parameter int unsigned        W       = 1,
  parameter logic [W-1:0]       RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/otg_ms_timer.sv
module otg_ms_timer #(
  parameter int unsigned CYCLES_PER_MS = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES_PER_MS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYCLES_PER_MS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> !tick_q); // R4
  AST_TICK_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> (cnt_q == '0)); // R4
endmodule

// File: rtl/otg_line_filter.sv
module otg_line_filter
  import otg_irq_pkg::*;
#(
  parameter int unsigned CYCLES_PER_MS = 125000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] line_i,
  output logic       chg_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES_PER_MS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYCLES_PER_MS - 1);

  logic [1:0]       line_q, settled_q;
  logic [CNT_W-1:0] cnt_q;
  logic             chg_q;
  logic             held;

  assign held = (line_i == line_q) && (cnt_q == CNT_LAST);

  // stability counter restarts on every change of the sampled line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= LINE_J;
      cnt_q  <= '0;
    end else if (line_i != line_q) begin
      line_q <= line_i;
      cnt_q  <= '0;
    end else if (cnt_q != CNT_LAST) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      settled_q <= LINE_J;
      chg_q     <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (held && (line_q != settled_q)) begin
        settled_q <= line_q;
        chg_q     <= 1'b1;
      end
    end
  end

  assign chg_o = chg_q;

  AST_LINE_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q |=> !chg_q); // R5
  AST_SETTLED_ONLY_ON_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(settled_q) |-> chg_q); // R5
endmodule

// File: rtl/otg_irq_monitor.sv
module otg_irq_monitor
  import otg_irq_pkg::*;
#(
  parameter int unsigned CYCLES_PER_MS = 125000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        id_i,
  input  logic        avbus_vld_i,
  input  logic        bsess_vld_i,
  input  logic        bsess_end_i,
  input  logic [1:0]  line_i,
  input  logic        wr_en_i,
  input  logic        wr_sel_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] status_o,
  output logic [31:0] enable_o,
  output logic        irq_o
);
  localparam int unsigned LVL_W = 4;

  logic [LVL_W-1:0]  lvl_in, lvl_s, lvl_prev_q, lvl_chg;
  logic [1:0]        line_s;
  logic              tick, line_chg;
  logic [STAT_W-1:0] set_vec, clr_vec;
  logic [STAT_W-1:0] status_q, en_q;

  // level order: {id, bsess_vld, bsess_end, avbus}
  assign lvl_in = {id_i, bsess_vld_i, bsess_end_i, avbus_vld_i};

  otg_sync #(.W(LVL_W), .RST_VAL('0)) u_lvl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lvl_in),
    .q_o   (lvl_s)
  );

  otg_sync #(.W(2), .RST_VAL(LINE_J)) u_line_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  otg_ms_timer #(.CYCLES_PER_MS(CYCLES_PER_MS)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  otg_line_filter #(.CYCLES_PER_MS(CYCLES_PER_MS)) u_line (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(line_s),
    .chg_o (line_chg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_prev_q <= '0;
    else         lvl_prev_q <= lvl_s;
  end

  assign lvl_chg = lvl_s ^ lvl_prev_q;

  always_comb begin
    set_vec            = '0;
    set_vec[BIT_AVBUS] = lvl_chg[0];
    set_vec[BIT_BEND]  = lvl_chg[1];
    set_vec[BIT_BVLD]  = lvl_chg[2];
    set_vec[BIT_ID]    = lvl_chg[3];
    set_vec[BIT_LINE]  = line_chg;
    set_vec[BIT_TICK]  = tick;
  end

  assign clr_vec = (wr_en_i && !wr_sel_i) ? wr_data_i[STAT_W-1:0] : '0;

  // hardware set takes priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= ((status_q & ~clr_vec) | set_vec) & IMPL_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 en_q <= '0;
    else if (wr_en_i && wr_sel_i) en_q <= wr_data_i[STAT_W-1:0] & IMPL_MASK;
  end

  assign status_o = {{(32-STAT_W){1'b0}}, status_q};
  assign enable_o = {{(32-STAT_W){1'b0}}, en_q};
  assign irq_o    = |(status_q & en_q);

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i) |=>
      ((status_q & $past(wr_data_i[STAT_W-1:0] & ~set_vec)) == '0)); // R6
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec))); // R9
  AST_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_en_i) |=> irq_o); // R8
  AST_EN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_sel_i) |=> $stable(en_q)); // R7
endmodule

// File: tb/otg_irq_monitor_tb.sv
module otg_irq_monitor_tb;
  localparam int unsigned MS = 40;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        id_i = 1'b0, avbus_vld_i = 1'b0, bsess_vld_i = 1'b0, bsess_end_i = 1'b0;
  logic [1:0]  line_i = 2'b01;
  logic        wr_en_i = 1'b0, wr_sel_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] status_o, enable_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int          sel;   // 0 status, 1 enable, 2 irq
    logic [31:0] mask;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];

  always #4 clk_i = ~clk_i;

  otg_irq_monitor #(.CYCLES_PER_MS(MS)) u_dut (
    .clk_i, .rst_ni, .id_i, .avbus_vld_i, .bsess_vld_i, .bsess_end_i,
    .line_i, .wr_en_i, .wr_sel_i, .wr_data_i, .status_o, .enable_o, .irq_o
  );

  // monitor: compares queued expectations shortly after each edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = sb_q.pop_front();
        case (it.sel)
          0:       got = status_o;
          1:       got = enable_o;
          default: got = {31'b0, irq_o};
        endcase
        n_chk++;
        if ((got & it.mask) !== (it.exp & it.mask)) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h (mask %h)", it.req, got & it.mask,
                   it.exp & it.mask, it.mask);
        end
      end
    end
  end

  task automatic chk(input int sel, input logic [31:0] mask, input logic [31:0] exp,
                     input string req);
    item_t it;
    it.sel = sel; it.mask = mask; it.exp = exp; it.req = req;
    sb_q.push_back(it);
    @(posedge clk_i);
    #3;
  endtask

  task automatic wr(input logic sel, input logic [31:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  localparam logic [31:0] NT = 32'hFFFF_FFBF; // all but tick bit

  initial begin
    idle(3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(0, 32'hFFFF_FFFF, 32'h0, "R1 status");
    chk(1, 32'hFFFF_FFFF, 32'h0, "R1 enable");
    chk(2, 32'h1, 32'h0, "R1 irq");

    // R2 ID both directions
    @(negedge clk_i); id_i = 1'b1; idle(6);
    chk(0, NT, 32'h80, "R2 id rise");
    wr(1'b0, 32'h0000_0000); idle(1);
    chk(0, NT, 32'h80, "R6 zero write keeps");
    wr(1'b0, 32'h0000_007F); idle(1);
    chk(0, NT, 32'h80, "R6 other-bit write keeps");
    wr(1'b0, 32'h0000_0080); idle(1);
    chk(0, NT, 32'h00, "R6 clear id");
    @(negedge clk_i); id_i = 1'b0; idle(6);
    chk(0, NT, 32'h80, "R2 id fall");
    wr(1'b0, 32'hFFFF_FFFF); idle(1);
    chk(0, NT, 32'h00, "R6 reserved read zero");

    // R3 VBUS and session levels
    @(negedge clk_i); avbus_vld_i = 1'b1; idle(6);
    chk(0, NT, 32'h01, "R3 avbus rise");
    @(negedge clk_i); bsess_end_i = 1'b1; idle(6);
    chk(0, NT, 32'h05, "R3 bsess_end rise");
    @(negedge clk_i); bsess_vld_i = 1'b1; idle(6);
    chk(0, NT, 32'h0D, "R3 bsess_vld rise");
    wr(1'b0, 32'h0D); idle(1);
    @(negedge clk_i); avbus_vld_i = 1'b0; bsess_vld_i = 1'b0; idle(6);
    chk(0, NT, 32'h09, "R3 falls");
    wr(1'b0, 32'hFF); idle(1);

    // R7 enable register
    wr(1'b1, 32'hFFFF_FFFF); idle(1);
    chk(1, 32'hFFFF_FFFF, 32'h0000_00ED, "R7 enable reserved zero");
    wr(1'b1, 32'h0000_0080); idle(1);
    chk(1, 32'hFFFF_FFFF, 32'h0000_0080, "R7 enable load");

    // R8 interrupt
    @(negedge clk_i); id_i = 1'b1; idle(6);
    chk(2, 32'h1, 32'h1, "R8 irq high");
    wr(1'b1, 32'h0000_0008); idle(1);
    chk(2, 32'h1, 32'h0, "R8 irq masked");
    wr(1'b1, 32'h0000_0080); idle(1);
    chk(2, 32'h1, 32'h1, "R8 irq unmasked");
    wr(1'b0, 32'h80); idle(1);
    chk(2, 32'h1, 32'h0, "R8 irq cleared");
    wr(1'b1, 32'h0); idle(1);

    // R9 set beats clear on the same edge
    @(negedge clk_i); id_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_data_i = 32'h80;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
    idle(1);
    chk(0, 32'h80, 32'h80, "R9 set wins");
    wr(1'b0, 32'h80); idle(1);

    // R4 tick
    wr(1'b0, 32'h40); idle(MS + 5);
    chk(0, 32'h40, 32'h40, "R4 tick set");

    // R5 line filter
    wr(1'b0, 32'hFF); idle(1);
    @(negedge clk_i); line_i = 2'b10; idle(MS / 4);
    @(negedge clk_i); line_i = 2'b01; idle(MS + 20);
    chk(0, 32'h20, 32'h00, "R5 glitch ignored");
    @(negedge clk_i); line_i = 2'b10; idle(MS / 2);
    chk(0, 32'h20, 32'h00, "R5 not before window");
    idle(MS);
    chk(0, 32'h20, 32'h20, "R5 J to K");
    wr(1'b0, 32'h20); idle(2 * MS);
    chk(0, 32'h20, 32'h00, "R5 settled no refire");
    @(negedge clk_i); line_i = 2'b00; idle(MS + 10);
    chk(0, 32'h20, 32'h20, "R5 K to SE0");
    wr(1'b0, 32'h20); idle(1);
    @(negedge clk_i); line_i = 2'b01; idle(MS + 10);
    chk(0, 32'h20, 32'h20, "R5 SE0 to J");

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    #10;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule